// File: doc/BRIEF.md
# Block-Granular DMA Channel

This block is a single DMA channel that moves 16-bit half-words between an on-chip FIFO and system memory. Work is organised in fixed blocks of 64 bytes (32 half-words). Software programs a start address and a number of blocks, then sets a direction and an enable bit. The channel issues one memory request per half-word at consecutive addresses. After each block it decrements the block count. When the count runs out it flags a terminal-count event, which can raise an interrupt.

Software reaches the FIFO through a 16-bit data port. In write-to-memory mode software fills the FIFO and the channel drains it into memory. In read-from-memory mode the channel fills the FIFO from memory and software drains it. With auto-reload set, the channel goes back to the stored start address and count after the last block. A transfer is never allowed to cross a 512 KB address region; an attempt to do so raises a sticky error and stops the channel.

Top module: `blkdma_channel`

## Requirements
- R1: After reset the mode/status word reads 0x0000_0400 (only the FIFO-empty flag set). The current address and block count read 0, and `irq` and `mem_req` are low.
- R2: Register select 4 is the FIFO data port. A write pushes `reg_wdata[15:0]`, and a read (with `reg_re`) returns and pops the oldest entry. The status word reports the FIFO level in half-words in bits 7:0, empty in bit 10 and full in bit 11 (at 32 entries). A push into a full FIFO is dropped.
- R3: Writing mode bit 31 empties the FIFO. The bit always reads back as 0.
- R4: With enable (bit 30) and direction bit 27 set to 1 (into memory), a block burst starts only once the FIFO holds 32 half-words. The channel then issues 32 writes at consecutive half-word addresses, carrying the FIFO data in order.
- R5: With direction 0 (from memory), a block burst starts only when the FIFO has room for 32 half-words. Each read response is pushed into the FIFO.
- R6: The current address (select 3) advances by 2 per half-word. The remaining block count (select 2) drops by one per completed block, and the channel stays idle at a count of 0.
- R7: When the count reaches 0, the pending flag (status bit 8) is set. `irq` is the pending flag AND the interrupt-enable bit 28. Any write to the mode register (select 1) clears the pending flag.
- R8: With auto-reload (bit 29), reaching a count of 0 reloads the current address from the load-address register (select 0) and the count from the last value written to select 2. The channel then continues once the FIFO condition allows.
- R9: Suppose an address step would carry into bit 19 while blocks remain. Then the error flag (status bit 9) is set, the address wraps within its 512 KB region and no further bursts start. If the carry happens on the final block, no error is raised. Writing mode bit 26 clears the error flag.
- R10: Clearing the enable bit stops the channel after the half-word in flight. The address and count stay readable, and re-enabling resumes the block where it stopped.
- R11: Once raised, `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack` is seen.
- R12: The load-address register forces its low 6 bits to zero. Writing it also sets the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register select: 0 load address, 1 mode/status, 2 block count, 3 current address, 4 FIFO data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the FIFO on select 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_sel` |
| mem_req | output | 1 | Memory half-word request |
| mem_we | output | 1 | 1 = write into memory, 0 = read from memory |
| mem_addr | output | 32 | Byte address of the half-word |
| mem_wdata | output | 16 | Write data (FIFO head) |
| mem_ack | input | 1 | Memory accepts/completes the request this cycle |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| irq | output | 1 | Terminal-count interrupt |

## Verification
Register writes take effect at the clock edge that samples them, so a value written is visible on `reg_rdata` from the following negative edge. A burst's first `mem_req` appears one cycle after its start condition becomes true, because the sequencer state is registered. Block-end results (count, address, pending, error) settle at the edge that takes the 32nd acknowledge. The bench therefore drives everything at negative edges and reads registers half a cycle after the drive. After each burst it waits for four idle request cycles before it compares the address, count, status and logged memory traffic. Stalled acknowledges are mixed in so that the hold rule and the halt/resume path see requests that stay open for more than one cycle.

// File: rtl/blkdma_pkg.sv
// Shared definitions for the block DMA channel: register selects, mode and
// status bit positions, and the sequencer state type.
package blkdma_pkg;

    typedef enum logic [2:0] {
        RS_LOAD = 3'd0,
        RS_MODE = 3'd1,
        RS_BLK  = 3'd2,
        RS_CUR  = 3'd3,
        RS_FIFO = 3'd4
    } reg_sel_e;

    // mode register, written fields
    localparam int MB_FLUSH  = 31;
    localparam int MB_EN     = 30;
    localparam int MB_AUTO   = 29;
    localparam int MB_IEN    = 28;
    localparam int MB_DIR    = 27;
    localparam int MB_CLRERR = 26;

    // mode register, status fields on read
    localparam int SB_FULL  = 11;
    localparam int SB_EMPTY = 10;
    localparam int SB_ERR   = 9;
    localparam int SB_PEND  = 8;

    typedef enum logic {
        XS_IDLE  = 1'b0,
        XS_BURST = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/blkdma_fifo.sv
// Half-word FIFO between the register port and the transfer sequencer.
// Assumes DEPTH is a power of two so the pointers wrap by overflow.
// A push into a full FIFO and a pop from an empty one are ignored; flush
// has priority over both.
module blkdma_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop,
    output logic [DW-1:0]   head,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0]   store [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [LVLW-1:0] cnt;
    logic            do_push, do_pop;

    assign full    = (cnt == LVLW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];
    assign level   = cnt;

    // storage write port
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            store[wr_ptr] <= push_data;
        end
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LVLW'(DEPTH));

    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == LVLW'(DEPTH)));

    p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/blkdma_xfer.sv
// Transfer sequencer: owns the current address and remaining block count,
// starts a block (or the rest of a halted block) when enabled and the FIFO
// level allows, steps one half-word per memory acknowledge, handles terminal
// count with optional reload, and flags a carry into the region bit.
// Assumes block-aligned start addresses (enforced by the register file).
module blkdma_xfer #(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int DEPTH     = 32,
    parameter int BLK_HW    = 32,
    parameter int BOUND_BIT = 19,
    parameter int LVLW      = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            dir_in,
    input  logic            autold,
    input  logic            err,
    input  logic [LVLW-1:0] lvl,
    input  logic [AW-1:0]   load_addr,
    input  logic [CW-1:0]   reload_cnt,
    input  logic            ld_addr_wr,
    input  logic            ld_cnt_wr,
    input  logic [AW-1:0]   ld_val,
    input  logic            mem_ack,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   cur_addr,
    output logic [CW-1:0]   blk_left,
    output logic            push,
    output logic            pop,
    output logic            tc_evt,
    output logic            xerr_evt
);
    import blkdma_pkg::*;

    localparam int BW   = $clog2(BLK_HW);
    localparam int LOWW = BOUND_BIT - 1;

    xfer_state_e     state_q;
    logic [BW-1:0]   beat_q;
    logic [AW-1:0]   cur_q;
    logic [CW-1:0]   left_q;
    logic            dir_q;

    logic            ack, last, carry, start, room_ok;
    logic [LOWW-1:0] low_nx;
    logic [AW-1:0]   step_addr;
    logic [CW-1:0]   left_dec;
    logic [LVLW:0]   need, free_w;

    // how many FIFO slots or entries the rest of the block needs
    always_comb begin
        need    = (LVLW+1)'(BLK_HW) - (LVLW+1)'(beat_q);
        free_w  = (LVLW+1)'(DEPTH) - (LVLW+1)'(lvl);
        room_ok = dir_in ? ((LVLW+1)'(lvl) >= need) : (free_w >= need);
    end

    // per-beat next values and block-end decisions
    always_comb begin
        ack                = (state_q == XS_BURST) && mem_ack;
        last               = (beat_q == BW'(BLK_HW - 1));
        {carry, low_nx}    = {1'b0, cur_q[BOUND_BIT-1:1]} + 1'b1;
        step_addr          = {cur_q[AW-1:BOUND_BIT], low_nx, 1'b0};
        left_dec           = left_q - 1'b1;
        tc_evt             = ack && last && (left_dec == '0);
        xerr_evt           = ack && carry && !(last && (left_dec == '0));
        start              = (state_q == XS_IDLE) && en && !err &&
                             (left_q != '0) && room_ok;
    end

    // sequencer state, beat counter, address and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            beat_q  <= '0;
            cur_q   <= '0;
            left_q  <= '0;
            dir_q   <= 1'b0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    if (start) begin
                        state_q <= XS_BURST;
                        dir_q   <= dir_in;
                    end
                end
                XS_BURST: begin
                    if (ack) begin
                        beat_q <= last ? '0 : beat_q + 1'b1;
                        if (last || !en || xerr_evt) begin
                            state_q <= XS_IDLE;
                        end
                        if (last && (left_dec == '0) && autold) begin
                            cur_q  <= load_addr;
                            left_q <= reload_cnt;
                        end else begin
                            cur_q <= step_addr;
                            if (last) left_q <= left_dec;
                        end
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
            if (ld_addr_wr) begin
                cur_q  <= ld_val;
                beat_q <= '0;
            end
            if (ld_cnt_wr) begin
                left_q <= ld_val[CW-1:0];
                beat_q <= '0;
            end
        end
    end

    assign mem_req  = (state_q == XS_BURST);
    assign mem_we   = dir_q;
    assign cur_addr = cur_q;
    assign blk_left = left_q;
    assign push     = ack && !dir_q;
    assign pop      = ack && dir_q;

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !ld_addr_wr) |=>
            (mem_req && $stable(cur_addr) && $stable(mem_we)));

    p_block_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && beat_q == '0) |-> (cur_addr[$clog2(2*BLK_HW)-1:0] == '0));

    p_no_start_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !$past(err));

    p_region_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_addr_wr && !tc_evt) |=> $stable(cur_addr[AW-1:BOUND_BIT]));

endmodule

// File: rtl/blkdma_regs.sv
// Software-visible register file: load address, block reload count, mode
// control bits, sticky pending and error flags, self-clearing flush and
// error-clear commands, and the combinational read-back mux.
// Assumes one register access per cycle; event sets win over clears.
module blkdma_regs #(
    parameter int AW     = 32,
    parameter int DW     = 16,
    parameter int CW     = 16,
    parameter int BLK_HW = 32,
    parameter int LVLW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      reg_sel,
    input  logic            reg_we,
    input  logic            reg_re,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [LVLW-1:0] fifo_lvl,
    input  logic            fifo_full,
    input  logic            fifo_empty,
    input  logic [DW-1:0]   fifo_head,
    input  logic [AW-1:0]   cur_addr,
    input  logic [CW-1:0]   blk_left,
    input  logic            tc_evt,
    input  logic            xerr_evt,
    output logic            en,
    output logic            dir,
    output logic            autold,
    output logic            err,
    output logic            flush,
    output logic            cpu_push,
    output logic            cpu_pop,
    output logic            ld_addr_wr,
    output logic            ld_cnt_wr,
    output logic [AW-1:0]   ld_val,
    output logic [AW-1:0]   load_addr,
    output logic [CW-1:0]   reload_cnt,
    output logic            irq
);
    import blkdma_pkg::*;

    localparam int BLK_BYTES = 2 * BLK_HW;

    logic          ien, pend;
    logic          mode_wr, clr_err_cmd;
    logic [31:0]   mode_word;

    assign mode_wr     = reg_we && (reg_sel == RS_MODE);
    assign clr_err_cmd = mode_wr && reg_wdata[MB_CLRERR];
    assign flush       = mode_wr && reg_wdata[MB_FLUSH];
    assign cpu_push    = reg_we && (reg_sel == RS_FIFO);
    assign cpu_pop     = reg_re && (reg_sel == RS_FIFO);
    assign ld_addr_wr  = reg_we && (reg_sel == RS_LOAD);
    assign ld_cnt_wr   = reg_we && (reg_sel == RS_BLK);
    assign ld_val      = ld_addr_wr ? (AW'(reg_wdata) & ~AW'(BLK_BYTES - 1))
                                    : AW'(reg_wdata);

    // control fields and reload values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            dir        <= 1'b0;
            autold     <= 1'b0;
            ien        <= 1'b0;
            load_addr  <= '0;
            reload_cnt <= '0;
        end else begin
            if (mode_wr) begin
                en     <= reg_wdata[MB_EN];
                dir    <= reg_wdata[MB_DIR];
                autold <= reg_wdata[MB_AUTO];
                ien    <= reg_wdata[MB_IEN];
            end
            if (ld_addr_wr) load_addr  <= ld_val;
            if (ld_cnt_wr)  reload_cnt <= CW'(reg_wdata);
        end
    end

    // sticky flags: hardware event sets, software write clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (tc_evt)       pend <= 1'b1;
            else if (mode_wr) pend <= 1'b0;
            if (xerr_evt)          err <= 1'b1;
            else if (clr_err_cmd)  err <= 1'b0;
        end
    end

    assign irq = pend && ien;

    // mode/status word assembly
    always_comb begin
        mode_word          = '0;
        mode_word[MB_EN]   = en;
        mode_word[MB_AUTO] = autold;
        mode_word[MB_IEN]  = ien;
        mode_word[MB_DIR]  = dir;
        mode_word[SB_FULL] = fifo_full;
        mode_word[SB_EMPTY]= fifo_empty;
        mode_word[SB_ERR]  = err;
        mode_word[SB_PEND] = pend;
        mode_word[7:0]     = 8'(fifo_lvl);
    end

    // read-back mux
    always_comb begin
        case (reg_sel)
            RS_LOAD: reg_rdata = 32'(load_addr);
            RS_MODE: reg_rdata = mode_word;
            RS_BLK:  reg_rdata = 32'(blk_left);
            RS_CUR:  reg_rdata = 32'(cur_addr);
            RS_FIFO: reg_rdata = 32'(fifo_head);
            default: reg_rdata = '0;
        endcase
    end

    p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> pend);

    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !tc_evt) |=> !pend);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_err_cmd) |=> err);

    p_load_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_addr_wr |=> (load_addr[$clog2(BLK_BYTES)-1:0] == '0));

endmodule

// File: rtl/blkdma_channel.sv
// Top of the block DMA channel: connects the register file, the half-word
// FIFO and the transfer sequencer, and arbitrates the FIFO ports between
// software and the sequencer (sequencer first on push; a shared pop
// removes one entry).
module blkdma_channel #(
    parameter int AW        = 32,
    parameter int DW        = 16,
    parameter int CW        = 16,
    parameter int DEPTH     = 32,
    parameter int BLK_HW    = 32,
    parameter int BOUND_BIT = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_sel,
    input  logic          reg_we,
    input  logic          reg_re,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq
);
    localparam int LVLW = $clog2(DEPTH + 1);

    logic            en, dir, autold, err, flush;
    logic            cpu_push, cpu_pop, x_push, x_pop;
    logic            ld_addr_wr, ld_cnt_wr, tc_evt, xerr_evt;
    logic [AW-1:0]   ld_val, load_addr, cur_addr;
    logic [CW-1:0]   reload_cnt, blk_left;
    logic [LVLW-1:0] lvl;
    logic            f_full, f_empty, f_push, f_pop;
    logic [DW-1:0]   f_head, f_din;

    assign f_push    = x_push || cpu_push;
    assign f_din     = x_push ? mem_rdata : DW'(reg_wdata);
    assign f_pop     = x_pop || cpu_pop;
    assign mem_addr  = cur_addr;
    assign mem_wdata = f_head;

    blkdma_regs #(
        .AW(AW), .DW(DW), .CW(CW), .BLK_HW(BLK_HW), .LVLW(LVLW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_re(reg_re),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_lvl(lvl), .fifo_full(f_full), .fifo_empty(f_empty),
        .fifo_head(f_head), .cur_addr(cur_addr), .blk_left(blk_left),
        .tc_evt(tc_evt), .xerr_evt(xerr_evt),
        .en(en), .dir(dir), .autold(autold), .err(err), .flush(flush),
        .cpu_push(cpu_push), .cpu_pop(cpu_pop),
        .ld_addr_wr(ld_addr_wr), .ld_cnt_wr(ld_cnt_wr), .ld_val(ld_val),
        .load_addr(load_addr), .reload_cnt(reload_cnt), .irq(irq)
    );

    blkdma_fifo #(
        .DW(DW), .DEPTH(DEPTH), .LVLW(LVLW)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(f_push), .push_data(f_din), .pop(f_pop),
        .head(f_head), .level(lvl), .full(f_full), .empty(f_empty)
    );

    blkdma_xfer #(
        .AW(AW), .CW(CW), .DEPTH(DEPTH), .BLK_HW(BLK_HW),
        .BOUND_BIT(BOUND_BIT), .LVLW(LVLW)
    ) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .en(en), .dir_in(dir), .autold(autold), .err(err), .lvl(lvl),
        .load_addr(load_addr), .reload_cnt(reload_cnt),
        .ld_addr_wr(ld_addr_wr), .ld_cnt_wr(ld_cnt_wr), .ld_val(ld_val),
        .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
        .cur_addr(cur_addr), .blk_left(blk_left),
        .push(x_push), .pop(x_pop), .tc_evt(tc_evt), .xerr_evt(xerr_evt)
    );

    p_irq_needs_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(tc_evt) || $past(reg_we)));

endmodule

// File: tb/sim_blkdma_channel.sv
module sim_blkdma_channel;
    localparam logic [31:0] M_FLUSH = 32'h8000_0000;
    localparam logic [31:0] M_EN    = 32'h4000_0000;
    localparam logic [31:0] M_AUTO  = 32'h2000_0000;
    localparam logic [31:0] M_IEN   = 32'h1000_0000;
    localparam logic [31:0] M_DIRW  = 32'h0800_0000;
    localparam logic [31:0] M_CLRE  = 32'h0400_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0, irq;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = '0;

    int n_chk = 0, n_bad = 0, acks = 0, wlog_n = 0, hold_err = 0;
    logic [31:0] wlog_a [128];
    logic [15:0] wlog_d [128];
    logic stall_on = 1'b0, tog = 1'b0, done = 1'b0;
    logic prev_open = 1'b0;
    logic [31:0] prev_addr = '0;

    always #5 clk = ~clk;

    blkdma_channel u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    // memory model: answers at the negative edge, optionally every other cycle
    always @(negedge clk) begin
        tog       <= ~tog;
        mem_ack   <= mem_req && (!stall_on || tog);
        mem_rdata <= mem_addr[15:0] ^ 16'hA5A5;
    end

    // traffic log and request-hold monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_open && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
            prev_open <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
            if (mem_req && mem_ack) begin
                acks <= acks + 1;
                if (mem_we && wlog_n < 128) begin
                    wlog_a[wlog_n] <= mem_addr;
                    wlog_d[wlog_n] <= mem_wdata;
                    wlog_n <= wlog_n + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic pop(output logic [15:0] d);
        @(negedge clk);
        reg_sel = 3'd4; reg_re = 1'b1;
        #1 d = reg_rdata[15:0];
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (!mem_req) q++; else q = 0;
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        acks = 0; wlog_n = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd1, v); chk("R1 mode after reset", v, 32'h0000_0400);
        rd(3'd3, v); chk("R1 cur addr after reset", v, 32'h0);
        rd(3'd2, v); chk("R1 count after reset", v, 32'h0);
        chk("R1 irq/req after reset", {30'd0, irq, mem_req}, 32'h0);
    endtask

    task automatic t_fifo_port();
        logic [31:0] v;
        logic [15:0] h;
        for (int i = 0; i < 3; i++) wr(3'd4, 32'h0000_AB00 + i);
        rd(3'd1, v); chk("R2 level 3", v & 32'hFFF, 32'h003);
        for (int i = 0; i < 3; i++) begin
            pop(h); chk("R2 pop order", 32'(h), 32'h0000_AB00 + i);
        end
        for (int i = 0; i < 33; i++) wr(3'd4, 32'h0000_C000 + i);
        rd(3'd1, v); chk("R2 full flag and level", v & 32'hFFF, 32'h820);
        pop(h); chk("R2 extra push dropped, head", 32'(h), 32'h0000_C000);
        wr(3'd1, M_FLUSH);
        rd(3'd1, v); chk("R3 flush empties and self-clears", v, 32'h0000_0400);
    endtask

    task automatic t_write_mem();
        logic [31:0] v;
        int bad = 0;
        clear_log();
        wr(3'd0, 32'h0000_1000);
        wr(3'd2, 32'd2);
        wr(3'd1, M_EN | M_IEN | M_DIRW);
        for (int i = 0; i < 31; i++) wr(3'd4, 32'h0000_5000 + i);
        repeat (10) @(negedge clk);
        chk("R4 no burst below a full block", 32'(acks), 32'd0);
        wr(3'd4, 32'h0000_501F);
        wait_idle();
        chk("R4 32 writes issued", 32'(wlog_n), 32'd32);
        for (int i = 0; i < 32; i++)
            if (wlog_a[i] !== 32'h1000 + 2*i || wlog_d[i] !== 16'h5000 + 16'(i)) bad++;
        chk("R4 write addresses and data in order", 32'(bad), 32'd0);
        rd(3'd2, v); chk("R6 count after one block", v, 32'd1);
        rd(3'd3, v); chk("R6 address after one block", v, 32'h0000_1040);
        chk("R7 no irq before tc", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 32; i++) wr(3'd4, 32'h0000_6000 + i);
        wait_idle();
        rd(3'd2, v); chk("R6 count reaches zero", v, 32'd0);
        rd(3'd3, v); chk("R6 address after two blocks", v, 32'h0000_1080);
        rd(3'd1, v); chk("R7 pending bit set", v & 32'h100, 32'h100);
        chk("R7 irq with enable", {31'd0, irq}, 32'd1);
        for (int i = 0; i < 32; i++) wr(3'd4, 32'h0000_7000 + i);
        repeat (6) @(negedge clk);
        chk("R6 idle at zero count", 32'(acks), 32'd64);
        wr(3'd1, M_FLUSH);
        rd(3'd1, v); chk("R7 mode write clears pending", v & 32'h100, 32'h0);
        chk("R7 irq drops", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_read_mem();
        logic [31:0] v;
        logic [15:0] h;
        int bad = 0;
        clear_log();
        stall_on = 1'b1;
        wr(3'd0, 32'h0000_2000);
        wr(3'd2, 32'd1);
        wr(3'd4, 32'h0000_1111);
        wr(3'd1, M_EN);
        repeat (10) @(negedge clk);
        chk("R5 no burst without room", 32'(acks), 32'd0);
        wr(3'd1, M_EN | M_FLUSH);
        wait_idle();
        chk("R5 32 reads issued", 32'(acks), 32'd32);
        rd(3'd1, v); chk("R5 FIFO filled, pend, no irq", v & 32'hFFF, 32'h920);
        chk("R7 irq masked", {31'd0, irq}, 32'd0);
        for (int i = 0; i < 32; i++) begin
            pop(h);
            if (h !== (16'(32'h2000 + 2*i) ^ 16'hA5A5)) bad++;
        end
        chk("R5 read data order", 32'(bad), 32'd0);
        chk("R11 request held through stalls", 32'(hold_err), 32'd0);
        stall_on = 1'b0;
        wr(3'd1, 32'h0);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        logic [15:0] h;
        clear_log();
        wr(3'd0, 32'h0000_3000);
        wr(3'd2, 32'd1);
        wr(3'd1, M_EN | M_AUTO);
        wait_idle();
        rd(3'd3, v); chk("R8 address reloaded", v, 32'h0000_3000);
        rd(3'd2, v); chk("R8 count reloaded", v, 32'd1);
        for (int i = 0; i < 32; i++) pop(h);
        wait_idle();
        chk("R8 second pass after drain", 32'(acks), 32'd64);
        rd(3'd3, v); chk("R8 address reloaded again", v, 32'h0000_3000);
        wr(3'd1, M_FLUSH);
    endtask

    task automatic t_boundary();
        logic [31:0] v;
        clear_log();
        wr(3'd0, 32'h0017_FFC0);
        wr(3'd2, 32'd2);
        wr(3'd1, M_EN);
        wait_idle();
        rd(3'd1, v); chk("R9 error flag set", v & 32'h200, 32'h200);
        rd(3'd3, v); chk("R9 address wraps in region", v, 32'h0010_0000);
        rd(3'd2, v); chk("R9 count after error", v, 32'd1);
        wr(3'd1, M_EN | M_FLUSH);
        repeat (8) @(negedge clk);
        chk("R9 no burst while error", 32'(acks), 32'd32);
        wr(3'd1, M_CLRE | M_FLUSH);
        rd(3'd1, v); chk("R9 error cleared", v & 32'h200, 32'h0);
        clear_log();
        wr(3'd0, 32'h0017_FFC0);
        wr(3'd2, 32'd1);
        wr(3'd1, M_EN);
        wait_idle();
        rd(3'd1, v); chk("R9 final block at edge, no error", v & 32'h300, 32'h100);
        wr(3'd1, M_FLUSH);
    endtask

    task automatic t_halt();
        logic [31:0] v;
        clear_log();
        stall_on = 1'b1;
        wr(3'd0, 32'h0000_4000);
        wr(3'd2, 32'd1);
        wr(3'd1, M_EN);
        repeat (9) @(negedge clk);
        wr(3'd1, 32'h0);
        wait_idle();
        chk("R10 halted mid-block", 32'(acks < 32 && acks > 0), 32'd1);
        rd(3'd3, v); chk("R10 address kept", v, 32'h0000_4000 + 32'(2*acks));
        rd(3'd2, v); chk("R10 count kept", v, 32'd1);
        wr(3'd1, M_EN);
        wait_idle();
        chk("R10 resume completes block", 32'(acks), 32'd32);
        rd(3'd3, v); chk("R10 address after resume", v, 32'h0000_4040);
        chk("R11 request held through stalls", 32'(hold_err), 32'd0);
        stall_on = 1'b0;
        wr(3'd1, M_FLUSH);
    endtask

    task automatic t_align();
        logic [31:0] v;
        wr(3'd0, 32'h1234_567F);
        rd(3'd0, v); chk("R12 load address aligned", v, 32'h1234_5640);
        rd(3'd3, v); chk("R12 current address follows", v, 32'h1234_5640);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fifo_port();
        t_write_mem();
        t_read_mem();
        t_reload();
        t_boundary();
        t_halt();
        t_align();
        finish_run();
    end
endmodule